// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and date in packed BCD: seconds, minutes, 24-hour hours, day of week, day of month, month, two-digit year and a one-bit century marker. A qualified one-pulse-per-second strobe from an external prescaler advances it. The carry moves up through the fields, with the month lengths and the leap-year February built into the day-of-month limit. A stop flag held in the seconds byte freezes all counting. A single-byte parallel port lets a controller set any field.

All eight register bytes come out on one flat 64-bit bus, byte N at bits 8N+7:8N. A serial front end can shift them out unchanged. Byte 7 is a plain control byte: the counter only stores its two upper bits for a neighbouring output stage.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the bytes read seconds 0x00, minutes 0x00, hours 0x00 with both century bits 0, day-of-week 0x01, date 0x01, month 0x01, year 0x00, control 0x80.
- R2: Byte layout: byte 0 = {stop, seconds[6:0]}, byte 1 = {0, minutes[6:0]}, byte 2 = {century-enable, century, hours[5:0]}, byte 3 = {5'b0, weekday[2:0]}, byte 4 = {2'b0, date[5:0]}, byte 5 = {3'b0, month[4:0]}, byte 6 = year, byte 7 = {ctl[1:0], 6'b0}. Reserved bits read 0 whatever was written.
- R3: Each tick adds one second in BCD. Seconds and minutes wrap from 0x59 to 0x00, and each wrap carries into the next field.
- R4: Hours wrap from 0x23 to 0x00. That wrap advances both the date and the day of week.
- R5: The day of week runs 1 to 7 and then returns to 1.
- R6: The date wraps to 0x01 and the month advances after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months except February.
- R7: February ends at 0x29 when the year's decimal value is divisible by 4 (year 00 included), and at 0x28 otherwise.
- R8: The month wraps from 0x12 to 0x01 and advances the year. The year wraps from 0x99 to 0x00.
- R9: When the year wraps from 0x99 to 0x00, the century bit (byte 2 bit 6) inverts if century-enable (byte 2 bit 7) is 1, and keeps its value if it is 0.
- R10: While the stop bit (byte 0 bit 7) is 1, ticks change no byte.
- R11: A write places wr_data, masked per R2, in byte wr_idx on the next cycle. Any tick in the same cycle is ignored.
- R12: Ticks never change byte 7. It changes only through writes to index 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Byte write strobe |
| wr_idx | input | 3 | Byte index to write (0 to 7) |
| wr_data | input | 8 | Byte value to write |
| regs_o | output | 64 | All eight bytes, byte N at bits 8N+7:8N |

## Verification
The range properties assume that every write loads a legal BCD value for its field and a date no later than the last day of the loaded month. A counter loaded with an illegal code would be outside what they cover. The bench only writes legal field values, and it moves the date close to the end of a month only after setting the month and year. Ticks arrive both back-to-back and sparsely, and some coincide with writes, since the design treats the tick as a plain enable with no spacing rule.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int NUM_REGS   = 8;
  localparam int BYTE_W     = 8;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int SEC_W      = 7;
  localparam int MIN_W      = 7;
  localparam int HOUR_W     = 6;
  localparam int WDAY_W     = 3;
  localparam int DATE_W     = 6;
  localparam int MONTH_W    = 5;
  localparam int YEAR_W     = 8;
  localparam int CTL_W      = 2;
  localparam int BUS_W      = NUM_REGS * BYTE_W;

  typedef enum logic [IDX_W-1:0] {
    IDX_SEC   = 3'd0,
    IDX_MIN   = 3'd1,
    IDX_HOUR  = 3'd2,
    IDX_WDAY  = 3'd3,
    IDX_DATE  = 3'd4,
    IDX_MONTH = 3'd5,
    IDX_YEAR  = 3'd6,
    IDX_CTRL  = 3'd7
  } reg_idx_e;

  // Packed-BCD increment of a two-digit value; the caller handles wrap.
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Decimal value divisible by 4: even tens need units 0/4/8, odd tens 2/6.
  function automatic logic bcd_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [5:0] bcd_month_last(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  // Bits that each byte keeps on a write; the rest read back as zero.
  function automatic logic [7:0] byte_keep_mask(input reg_idx_e idx);
    case (idx)
      IDX_SEC:   return 8'hFF;
      IDX_MIN:   return 8'h7F;
      IDX_HOUR:  return 8'hFF;
      IDX_WDAY:  return 8'h07;
      IDX_DATE:  return 8'h3F;
      IDX_MONTH: return 8'h1F;
      IDX_YEAR:  return 8'hFF;
      default:   return 8'hC0;
    endcase
  endfunction

endpackage

// File: rtl/bcd_field_ctr.sv
module bcd_field_ctr #(
  parameter int           W         = 8,
  parameter logic [W-1:0] FLOOR     = '0,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] value,
  output logic         wrap
);
  import bcd_cal_pkg::*;

  logic [W-1:0] incr;

  assign incr = W'(bcd_next(8'(value)));
  // At or beyond the limit counts as the last value, so the field stays bounded.
  assign wrap = step && (value >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)      value <= RESET_VAL;
    else if (load)   value <= load_val;
    else if (wrap)   value <= FLOOR;
    else if (step)   value <= incr;
  end

endmodule

// File: rtl/month_end_calc.sv
module month_end_calc (
  input  logic [bcd_cal_pkg::MONTH_W-1:0] month,
  input  logic [bcd_cal_pkg::YEAR_W-1:0]  year,
  output logic [bcd_cal_pkg::DATE_W-1:0]  last_date
);
  import bcd_cal_pkg::*;

  logic leap;

  assign leap      = bcd_leap(year);
  assign last_date = bcd_month_last(month, leap);

endmodule

// File: rtl/century_flag.sv
module century_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_enable,
  input  logic load_flag,
  input  logic year_wrap,
  output logic enable,
  output logic flag,
  output logic toggle
);

  assign toggle = year_wrap && enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= 1'b0;
      flag   <= 1'b0;
    end else if (load) begin
      enable <= load_enable;
      flag   <= load_flag;
    end else if (toggle) begin
      flag   <= ~flag;
    end
  end

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import bcd_cal_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_1hz,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [BUS_W-1:0]    regs_o
);

  logic [BYTE_W-1:0]   wr_masked;
  logic [NUM_REGS-1:0] ld_sel;

  logic                stop_q;
  logic [CTL_W-1:0]    ctl_q;
  logic                adv;

  logic [SEC_W-1:0]    sec_v;
  logic [MIN_W-1:0]    min_v;
  logic [HOUR_W-1:0]   hour_v;
  logic [WDAY_W-1:0]   wday_v;
  logic [DATE_W-1:0]   date_v;
  logic [MONTH_W-1:0]  month_v;
  logic [YEAR_W-1:0]   year_v;
  logic [DATE_W-1:0]   date_last;

  // Named carry events, also watched by the checker.
  logic sec_wrap, min_wrap, hr_wrap, date_wrap, mon_wrap, yr_wrap;
  logic unused_wday_wrap;
  logic cen_en, cen_flag, cen_toggle;

  logic [BYTE_W-1:0] rbyte [NUM_REGS];

  assign wr_masked = wr_data & byte_keep_mask(reg_idx_e'(wr_idx));

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_dec
      assign ld_sel[g] = wr_en && (wr_idx == IDX_W'(g));
    end
  endgenerate

  // A write cycle drops the tick; the stop flag gates it as well.
  assign adv = tick_1hz && !stop_q && !wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      ctl_q  <= 2'b10;
    end else begin
      if (ld_sel[IDX_SEC])  stop_q <= wr_masked[7];
      if (ld_sel[IDX_CTRL]) ctl_q  <= wr_masked[7:6];
    end
  end

  bcd_field_ctr #(.W(SEC_W), .FLOOR(7'h00), .RESET_VAL(7'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .load(ld_sel[IDX_SEC]), .load_val(wr_masked[SEC_W-1:0]),
    .step(adv), .limit(7'h59), .value(sec_v), .wrap(sec_wrap));

  bcd_field_ctr #(.W(MIN_W), .FLOOR(7'h00), .RESET_VAL(7'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .load(ld_sel[IDX_MIN]), .load_val(wr_masked[MIN_W-1:0]),
    .step(sec_wrap), .limit(7'h59), .value(min_v), .wrap(min_wrap));

  bcd_field_ctr #(.W(HOUR_W), .FLOOR(6'h00), .RESET_VAL(6'h00)) u_hour (
    .clk(clk), .rst_n(rst_n), .load(ld_sel[IDX_HOUR]), .load_val(wr_masked[HOUR_W-1:0]),
    .step(min_wrap), .limit(6'h23), .value(hour_v), .wrap(hr_wrap));

  bcd_field_ctr #(.W(WDAY_W), .FLOOR(3'd1), .RESET_VAL(3'd1)) u_wday (
    .clk(clk), .rst_n(rst_n), .load(ld_sel[IDX_WDAY]), .load_val(wr_masked[WDAY_W-1:0]),
    .step(hr_wrap), .limit(3'd7), .value(wday_v), .wrap(unused_wday_wrap));

  month_end_calc u_mend (
    .month(month_v), .year(year_v), .last_date(date_last));

  bcd_field_ctr #(.W(DATE_W), .FLOOR(6'h01), .RESET_VAL(6'h01)) u_date (
    .clk(clk), .rst_n(rst_n), .load(ld_sel[IDX_DATE]), .load_val(wr_masked[DATE_W-1:0]),
    .step(hr_wrap), .limit(date_last), .value(date_v), .wrap(date_wrap));

  bcd_field_ctr #(.W(MONTH_W), .FLOOR(5'h01), .RESET_VAL(5'h01)) u_month (
    .clk(clk), .rst_n(rst_n), .load(ld_sel[IDX_MONTH]), .load_val(wr_masked[MONTH_W-1:0]),
    .step(date_wrap), .limit(5'h12), .value(month_v), .wrap(mon_wrap));

  bcd_field_ctr #(.W(YEAR_W), .FLOOR(8'h00), .RESET_VAL(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .load(ld_sel[IDX_YEAR]), .load_val(wr_masked[YEAR_W-1:0]),
    .step(mon_wrap), .limit(8'h99), .value(year_v), .wrap(yr_wrap));

  century_flag u_cen (
    .clk(clk), .rst_n(rst_n), .load(ld_sel[IDX_HOUR]),
    .load_enable(wr_masked[7]), .load_flag(wr_masked[6]),
    .year_wrap(yr_wrap), .enable(cen_en), .flag(cen_flag), .toggle(cen_toggle));

  always_comb begin
    rbyte[IDX_SEC]   = {stop_q, sec_v};
    rbyte[IDX_MIN]   = {1'b0, min_v};
    rbyte[IDX_HOUR]  = {cen_en, cen_flag, hour_v};
    rbyte[IDX_WDAY]  = {5'b0, wday_v};
    rbyte[IDX_DATE]  = {2'b0, date_v};
    rbyte[IDX_MONTH] = {3'b0, month_v};
    rbyte[IDX_YEAR]  = year_v;
    rbyte[IDX_CTRL]  = {ctl_q, 6'b0};
  end

  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_pack
      assign regs_o[g*BYTE_W +: BYTE_W] = rbyte[g];
    end
  endgenerate

endmodule

// File: rtl/bcd_calendar_core_chk.sv
module bcd_calendar_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_1hz,
  input logic        wr_en,
  input logic [2:0]  wr_idx,
  input logic [7:0]  wr_data,
  input logic [63:0] regs_o,
  input logic        hour_wrap,
  input logic        year_wrap,
  input logic        cen_toggle
);

  // R2: reserved bits stay zero.
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[15] == 1'b0 && regs_o[31:27] == 5'b0 && regs_o[39:38] == 2'b0 &&
    regs_o[47:45] == 3'b0 && regs_o[61:56] == 6'b0);

  // R3: seconds stay a legal BCD code (assumes legal loads).
  assert_sec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[6:0] <= 7'h59 && regs_o[3:0] <= 4'd9);

  // R3: without a tick and without a write, nothing moves.
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !wr_en) |=> $stable(regs_o));

  // R5: weekday follows the hour wrap, 7 back to 1.
  assert_wday_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hour_wrap |=> regs_o[26:24] ==
      (($past(regs_o[26:24]) == 3'd7) ? 3'd1 : $past(regs_o[26:24]) + 3'd1));

  // R8: the year wraps to zero on its carry.
  assert_year_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    year_wrap |=> regs_o[55:48] == 8'h00);

  // R9: century bit inverts only when enabled.
  assert_century_R9: assert property (@(posedge clk) disable iff (!rst_n)
    year_wrap |=> regs_o[22] == ($past(regs_o[23]) ? !$past(regs_o[22]) : $past(regs_o[22])));

  assert_century_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cen_toggle |-> year_wrap);

  // R10: stop bit freezes all bytes on a tick.
  assert_stop_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && regs_o[7] && !wr_en) |=> $stable(regs_o));

  // R11: a minutes write wins over a tick in the same cycle.
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3'd1) |=> regs_o[15:8] == {1'b0, $past(wr_data[6:0])});

  // R12: control byte only moves on its own write.
  assert_ctrl_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx == 3'd7) |=> $stable(regs_o[63:56]));

endmodule

bind bcd_calendar_core bcd_calendar_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_data(wr_data), .regs_o(regs_o),
  .hour_wrap(hr_wrap), .year_wrap(yr_wrap), .cen_toggle(cen_toggle));

// File: tb/bcd_calendar_core_test.sv
module bcd_calendar_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = 3'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [63:0] regs_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // Reference model kept as plain integers.
  int m_sec = 0, m_min = 0, m_hr = 0, m_wd = 1, m_date = 1, m_mon = 1, m_yr = 0;
  int m_ceb = 0, m_cb = 0, m_st = 0, m_ctl = 'h80;

  always #2 clk = ~clk;

  bcd_calendar_core uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .regs_o(regs_o));

  function automatic int to_bcd(int n); return (n / 10) * 16 + (n % 10); endfunction
  function automatic int from_bcd(int b); return (b / 16) * 10 + (b % 16); endfunction

  function automatic int days_of(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] model_bus();
    logic [63:0] b;
    b[7:0]   = 8'((m_st << 7) | to_bcd(m_sec));
    b[15:8]  = 8'(to_bcd(m_min));
    b[23:16] = 8'((m_ceb << 7) | (m_cb << 6) | to_bcd(m_hr));
    b[31:24] = 8'(m_wd);
    b[39:32] = 8'(to_bcd(m_date));
    b[47:40] = 8'(to_bcd(m_mon));
    b[55:48] = 8'(to_bcd(m_yr));
    b[63:56] = 8'(m_ctl);
    return b;
  endfunction

  task automatic model_write(int i, int d);
    case (i)
      0: begin m_st = (d >> 7) & 1; m_sec = from_bcd(d & 'h7F); end
      1: m_min = from_bcd(d & 'h7F);
      2: begin m_ceb = (d >> 7) & 1; m_cb = (d >> 6) & 1; m_hr = from_bcd(d & 'h3F); end
      3: m_wd = d & 'h07;
      4: m_date = from_bcd(d & 'h3F);
      5: m_mon = from_bcd(d & 'h1F);
      6: m_yr = from_bcd(d);
      default: m_ctl = d & 'hC0;
    endcase
  endtask

  task automatic model_tick();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
    m_date++;
    if (m_date <= days_of(m_mon, m_yr)) return;
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_yr++;
    if (m_yr <= 99) return;
    m_yr = 0;
    if (m_ceb != 0) m_cb = 1 - m_cb;
  endtask

  task automatic compare_model();
    logic [63:0] exp;
    exp = model_bus();
    checks++;
    if (regs_o !== exp) begin
      fails++;
      $display("FAIL %s model compare: actual=%h expected=%h", cur_req, regs_o, exp);
    end
  endtask

  task automatic check_bits(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after compare.
  task automatic cyc(bit t, bit w, int i, int d);
    tick_1hz = t; wr_en = w; wr_idx = 3'(i); wr_data = 8'(d);
    @(posedge clk);
    if (w) model_write(i, d);
    else if (t && m_st == 0) model_tick();
    @(negedge clk);
    compare_model();
  endtask

  task automatic wr(int i, int d); cyc(1'b0, 1'b1, i, d); endtask
  task automatic tk(); cyc(1'b1, 1'b0, 0, 0); endtask

  task automatic set_eod(int yr, int mon, int date);
    wr(6, yr); wr(5, mon); wr(4, date);
    wr(1, 'h59); wr(0, 'h59);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check_bits("R1", regs_o, 64'h8000_0101_0100_0000);
    compare_model();

    cur_req = "R3";
    wr(0, 'h55);
    for (int k = 0; k < 10; k++) tk();
    check_bits("R3", {48'd0, regs_o[15:0]}, 64'h0105);
    for (int k = 0; k < 20; k++) begin cyc(1'b0, 1'b0, 0, 0); tk(); end

    cur_req = "R4";
    wr(3, 7); wr(4, 'h10); wr(2, 'h23); wr(1, 'h59); wr(0, 'h59);
    tk();
    check_bits("R4", {40'd0, regs_o[39:16]}, 64'h11_01_00);
    cur_req = "R5";
    check_bits("R5", {56'd0, regs_o[31:24]}, 64'h01);

    cur_req = "R6";
    wr(2, 'h23); set_eod('h25, 'h04, 'h30); tk();
    check_bits("R6", {48'd0, regs_o[47:32]}, 64'h0501);
    wr(2, 'h23); set_eod('h25, 'h01, 'h31); tk();
    check_bits("R6", {48'd0, regs_o[47:32]}, 64'h0201);
    wr(2, 'h23); set_eod('h25, 'h11, 'h30); tk();
    check_bits("R6", {48'd0, regs_o[47:32]}, 64'h1201);

    cur_req = "R7";
    wr(2, 'h23); set_eod('h23, 'h02, 'h28); tk();
    check_bits("R7", {48'd0, regs_o[47:32]}, 64'h0301);
    wr(2, 'h23); set_eod('h24, 'h02, 'h28); tk();
    check_bits("R7", {48'd0, regs_o[47:32]}, 64'h0229);
    wr(2, 'h23); wr(1, 'h59); wr(0, 'h59); tk();
    check_bits("R7", {48'd0, regs_o[47:32]}, 64'h0301);
    wr(2, 'h23); set_eod('h00, 'h02, 'h28); tk();
    check_bits("R7", {48'd0, regs_o[47:32]}, 64'h0229);
    wr(2, 'h23); set_eod('h18, 'h02, 'h28); tk();
    check_bits("R7", {48'd0, regs_o[47:32]}, 64'h0301);

    cur_req = "R8";
    wr(2, 'hA3); set_eod('h99, 'h12, 'h31); tk();
    check_bits("R8", {40'd0, regs_o[55:32]}, 64'h00_01_01);
    cur_req = "R9";
    check_bits("R9", {56'd0, regs_o[23:16]}, 64'hC0);
    wr(2, 'h63); set_eod('h99, 'h12, 'h31); tk();
    check_bits("R9", {56'd0, regs_o[23:16]}, 64'h40);

    cur_req = "R10";
    wr(0, 'hB0);
    for (int k = 0; k < 5; k++) tk();
    check_bits("R10", {56'd0, regs_o[7:0]}, 64'hB0);
    wr(0, 'h30); tk();
    check_bits("R10", {56'd0, regs_o[7:0]}, 64'h31);

    cur_req = "R11";
    cyc(1'b1, 1'b1, 0, 'h12);
    check_bits("R11", {56'd0, regs_o[7:0]}, 64'h12);
    cyc(1'b1, 1'b1, 5, 'h07);
    check_bits("R11", {48'd0, regs_o[15:0]}, 64'h0012);

    cur_req = "R2";
    wr(3, 'hFF); check_bits("R2", {56'd0, regs_o[31:24]}, 64'h07);
    wr(1, 'hC5); check_bits("R2", {56'd0, regs_o[15:8]}, 64'h45);
    wr(4, 'hD2); check_bits("R2", {56'd0, regs_o[39:32]}, 64'h12);
    wr(5, 'hE9); check_bits("R2", {56'd0, regs_o[47:40]}, 64'h09);

    cur_req = "R12";
    wr(7, 'hFF); check_bits("R12", {56'd0, regs_o[63:56]}, 64'hC0);
    for (int k = 0; k < 100; k++) tk();
    check_bits("R12", {56'd0, regs_o[63:56]}, 64'hC0);
    wr(7, 'h40); check_bits("R12", {56'd0, regs_o[63:56]}, 64'h40);

    cur_req = "R3";
    wr(3, 5); wr(2, 'h22); set_eod('h28, 'h02, 'h28);
    for (int k = 0; k < 12000; k++) begin
      if (k % 7 == 3) cyc(1'b0, 1'b0, 0, 0);
      tk();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule